// File: doc/BRIEF.md
# Circular Delay-Line Address Generator

This block produces the byte addresses for one circular audio delay buffer kept in byte-addressed external memory. Each stored sample is a 32-bit word holding a left and a right 16-bit channel, so every pointer moves in steps of four bytes. A write pointer walks the buffer once per sample and wraps back to the buffer's base. One or more read taps trail it, each by its own delay that can change while audio is running. The memory access logic reads and writes at the addresses it is given.

A delay is a small integer in coarse steps, where one step is a fixed number of samples (`STEP_SAMPLES`). When the system pulses the read strobe, the block takes a snapshot of the write pointer, the fill count, the buffer window and every tap's delay. A small state machine then updates the taps one per cycle through a single shared address calculator. It has two states. `SEQ_IDLE` holds all tap addresses. An accepted read strobe moves it to `SEQ_RUN`, which writes one tap per cycle in index order. After the last tap it returns to `SEQ_IDLE`. Until enough samples have been written since reset to cover a tap's delay, that tap follows the write pointer, so stale memory is never replayed.

Several buffers can share one memory. Each instance gets its own base, and the base of the next buffer is the first byte after the end of the previous one.

Top module: `dl_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `wr_addr` and every tap address are loaded with `base_addr`, and the count of written samples is cleared.
- R2: A cycle with `wr_inc` high advances `wr_addr` by 4 unless it is at the last word. A cycle with `wr_inc` low leaves `wr_addr` unchanged.
- R3: With `wr_inc` high and `wr_addr` equal to `base_addr + buf_len - 4`, the next `wr_addr` is `base_addr`.
- R4: Once primed, tap k's address is the snapshot write address minus `4 * d * STEP_SAMPLES`. Here d is the tap's delay field, taken from bits `[k*DELAY_W +: DELAY_W]` of `tap_delay`.
- R5: When that subtraction would fall below `base_addr`, `buf_len` is added back, so the tap reads from the end of the previous pass.
- R6: A tap is primed when the number of `wr_inc` pulses since reset (saturating at the largest possible delay) is at least `d * STEP_SAMPLES`. Until then its address equals the snapshot write address.
- R7: Delay inputs are sampled only when a read strobe is accepted. Changing them at any other time leaves every tap address unchanged.
- R8: A read strobe accepted at clock edge n updates tap k at edge n+1+k. Tap k keeps its old address until that edge.
- R9: A read strobe that arrives while the taps are being updated is ignored, and it does not start a second update.
- R10: Each tap uses only its own delay field.
- R11: Every write and tap address lies in `[base_addr, base_addr + buf_len - 4]` and is 4-byte aligned, given an aligned base, a `buf_len` that is a multiple of 4, and a `buf_len` larger than 4 times the largest delay in samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_inc | input | 1 | Advance the write pointer by one sample |
| rd_inc | input | 1 | Sample the delays and start updating the taps |
| base_addr | input | ADDR_W | First byte of this buffer |
| buf_len | input | ADDR_W | Buffer length in bytes |
| tap_delay | input | NUM_TAPS*DELAY_W | Packed per-tap delays in steps, tap 0 in the low field |
| wr_addr | output | ADDR_W | Current write address |
| tap_addr | output | NUM_TAPS*ADDR_W | Packed tap read addresses, tap 0 in the low word |

## Verification
The hardest situation to reach is a tap that has just become primed while the write pointer sits a few words past the base after a wrap. There the subtraction underflows and must be folded back by the buffer length. The bench uses a small configuration: a 16-sample buffer, 2 samples per step and delays up to 7. It runs the write pointer around the ring several times, and on every sample it changes both tap delays in a pattern that covers 0, the maximum, and values just above and below the fill count. That drives the unprimed, primed-direct and primed-folded cases in turn. Directed sequences then change delays between strobes, issue a strobe while an update is in progress, and sample the taps half-way through an update.

// File: rtl/dl_pkg.sv
package dl_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Largest delay in samples for a given field width and step size
    function automatic int max_delay_samples(input int delay_w, input int step);
        return ((1 << delay_w) - 1) * step;
    endfunction

endpackage

// File: rtl/dl_write_ptr.sv
module dl_write_ptr #(
    parameter int ADDR_W   = 32,
    parameter int FILL_W   = 16,
    parameter int FILL_MAX = 60960
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_inc,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] buf_len,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [FILL_W-1:0] fill_cnt
);

    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);
    localparam logic [FILL_W-1:0] FILL_SAT   = FILL_W'(FILL_MAX);

    logic [ADDR_W-1:0] wp_q;
    logic [FILL_W-1:0] fill_q;
    logic [ADDR_W-1:0] last_addr;
    logic              at_last;

    assign last_addr = base_addr + buf_len - WORD_BYTES;
    assign at_last   = (wp_q == last_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q   <= base_addr;
            fill_q <= '0;
        end else if (wr_inc) begin
            wp_q <= at_last ? base_addr : wp_q + WORD_BYTES;
            if (fill_q != FILL_SAT) begin
                fill_q <= fill_q + FILL_W'(1);
            end
        end
    end

    assign wr_addr  = wp_q;
    assign fill_cnt = fill_q;

    // R2
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_inc && wr_addr != last_addr) |=> wr_addr == $past(wr_addr) + WORD_BYTES);

    // R2
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_inc |=> $stable(wr_addr));

    // R3
    wr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_inc && wr_addr == last_addr) |=> wr_addr == $past(base_addr));

    // R11
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_addr - base_addr) < buf_len) && (wr_addr[1:0] == base_addr[1:0]));

endmodule

// File: rtl/dl_tap_calc.sv
module dl_tap_calc #(
    parameter int ADDR_W       = 32,
    parameter int FILL_W       = 16,
    parameter int DELAY_W      = 7,
    parameter int STEP_SAMPLES = 480
) (
    input  logic [ADDR_W-1:0]  wp,
    input  logic [FILL_W-1:0]  fill,
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W-1:0]  len,
    input  logic [DELAY_W-1:0] delay,
    output logic [ADDR_W-1:0]  tap
);

    logic [FILL_W-1:0] need_samples;
    logic [ADDR_W-1:0] off_bytes;
    logic [ADDR_W-1:0] rel;
    logic              primed;

    always_comb begin
        need_samples = FILL_W'(delay) * FILL_W'(STEP_SAMPLES);
        off_bytes    = ADDR_W'(need_samples) << 2;
        rel          = wp - base;
        primed       = (fill >= need_samples);
        if (!primed) begin
            tap = wp;
        end else if (rel >= off_bytes) begin
            tap = wp - off_bytes;
        end else begin
            tap = wp + len - off_bytes;
        end
    end

endmodule

// File: rtl/dl_tap_seq.sv
module dl_tap_seq
    import dl_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int NUM_TAPS     = 2,
    parameter int DELAY_W      = 7,
    parameter int FILL_W       = 16,
    parameter int STEP_SAMPLES = 480
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_inc,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [FILL_W-1:0]            fill_cnt,
    input  logic [ADDR_W-1:0]            base_addr,
    input  logic [ADDR_W-1:0]            buf_len,
    input  logic [NUM_TAPS*DELAY_W-1:0]  tap_delay,
    output logic [NUM_TAPS*ADDR_W-1:0]   tap_addr
);

    localparam int IDX_W = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TAPS - 1);

    seq_state_e state_q, state_d;

    logic [IDX_W-1:0]                      idx_q;
    logic [ADDR_W-1:0]                     wp_snap;
    logic [FILL_W-1:0]                     fill_snap;
    logic [ADDR_W-1:0]                     base_snap;
    logic [ADDR_W-1:0]                     len_snap;
    logic [NUM_TAPS-1:0][DELAY_W-1:0]      dly_snap;
    logic [NUM_TAPS-1:0][ADDR_W-1:0]       tap_q;
    logic [ADDR_W-1:0]                     calc_tap;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (rd_inc)             state_d = SEQ_RUN;
            SEQ_RUN:  if (idx_q == LAST_IDX)  state_d = SEQ_IDLE;
            default:                          state_d = SEQ_IDLE;
        endcase
    end

    // One address calculator shared by all taps
    dl_tap_calc #(
        .ADDR_W       (ADDR_W),
        .FILL_W       (FILL_W),
        .DELAY_W      (DELAY_W),
        .STEP_SAMPLES (STEP_SAMPLES)
    ) u_calc (
        .wp    (wp_snap),
        .fill  (fill_snap),
        .base  (base_snap),
        .len   (len_snap),
        .delay (dly_snap[idx_q]),
        .tap   (calc_tap)
    );

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            wp_snap   <= base_addr;
            fill_snap <= '0;
            base_snap <= base_addr;
            len_snap  <= buf_len;
            dly_snap  <= '0;
            for (int k = 0; k < NUM_TAPS; k++) begin
                tap_q[k] <= base_addr;
            end
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (rd_inc) begin
                        idx_q     <= '0;
                        wp_snap   <= wr_addr;
                        fill_snap <= fill_cnt;
                        base_snap <= base_addr;
                        len_snap  <= buf_len;
                        dly_snap  <= tap_delay;
                    end
                end
                SEQ_RUN: begin
                    tap_q[idx_q] <= calc_tap;
                    if (idx_q != LAST_IDX) begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign tap_addr = tap_q;

    // R8
    seq_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && rd_inc) |=> (state_q == SEQ_RUN && idx_q == '0));

    // R8
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN && idx_q != LAST_IDX)
            |=> (state_q == SEQ_RUN && idx_q == $past(idx_q) + IDX_W'(1)));

    // R9
    seq_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN) |=> $stable(dly_snap));

    // R7
    tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE) |=> $stable(tap_addr));

    // R11
    tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN)
            |-> (((calc_tap - base_snap) < len_snap) && (calc_tap[1:0] == base_snap[1:0])));

endmodule

// File: rtl/dl_addr_gen.sv
module dl_addr_gen
    import dl_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int NUM_TAPS     = 2,
    parameter int DELAY_W      = 7,
    parameter int STEP_SAMPLES = 480
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_inc,
    input  logic                         rd_inc,
    input  logic [ADDR_W-1:0]            base_addr,
    input  logic [ADDR_W-1:0]            buf_len,
    input  logic [NUM_TAPS*DELAY_W-1:0]  tap_delay,
    output logic [ADDR_W-1:0]            wr_addr,
    output logic [NUM_TAPS*ADDR_W-1:0]   tap_addr
);

    localparam int FILL_MAX = max_delay_samples(DELAY_W, STEP_SAMPLES);
    localparam int FILL_W   = $clog2(FILL_MAX + 1);

    logic [FILL_W-1:0] fill_cnt;

    dl_write_ptr #(
        .ADDR_W   (ADDR_W),
        .FILL_W   (FILL_W),
        .FILL_MAX (FILL_MAX)
    ) u_wptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_inc    (wr_inc),
        .base_addr (base_addr),
        .buf_len   (buf_len),
        .wr_addr   (wr_addr),
        .fill_cnt  (fill_cnt)
    );

    dl_tap_seq #(
        .ADDR_W       (ADDR_W),
        .NUM_TAPS     (NUM_TAPS),
        .DELAY_W      (DELAY_W),
        .FILL_W       (FILL_W),
        .STEP_SAMPLES (STEP_SAMPLES)
    ) u_taps (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_inc    (rd_inc),
        .wr_addr   (wr_addr),
        .fill_cnt  (fill_cnt),
        .base_addr (base_addr),
        .buf_len   (buf_len),
        .tap_delay (tap_delay),
        .tap_addr  (tap_addr)
    );

    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (wr_addr == $past(base_addr)));

endmodule

// File: tb/dl_addr_gen_tb.sv
module dl_addr_gen_tb;

    localparam int AW   = 16;
    localparam int NT   = 2;
    localparam int DW   = 3;
    localparam int STEP = 2;
    localparam int LEN  = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_inc = 1'b0;
    logic          rd_inc = 1'b0;
    logic [AW-1:0] base_addr = 16'h0100;
    logic [AW-1:0] buf_len = 16'(LEN);
    logic [NT*DW-1:0] tap_delay = '0;
    logic [AW-1:0] wr_addr;
    logic [NT*AW-1:0] tap_addr;

    int n_chk = 0;
    int n_fail = 0;

    logic [AW-1:0] m_wp;
    int            m_fill;
    logic [AW-1:0] e0, e1;

    always #2.5 clk = ~clk;

    dl_addr_gen #(
        .ADDR_W       (AW),
        .NUM_TAPS     (NT),
        .DELAY_W      (DW),
        .STEP_SAMPLES (STEP)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_inc    (wr_inc),
        .rd_inc    (rd_inc),
        .base_addr (base_addr),
        .buf_len   (buf_len),
        .tap_delay (tap_delay),
        .wr_addr   (wr_addr),
        .tap_addr  (tap_addr)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_tap(input logic [AW-1:0] wp, input int fill, input int d);
        int samp;
        int off;
        int rel;
        samp = d * STEP;
        if (fill < samp) return wp;
        off = 4 * samp;
        rel = int'(wp) - int'(base_addr);
        if (rel >= off) return AW'(int'(wp) - off);
        return AW'(int'(wp) - off + LEN);
    endfunction

    function automatic logic [AW-1:0] next_wp(input logic [AW-1:0] wp);
        if (int'(wp) == int'(base_addr) + LEN - 4) return base_addr;
        return AW'(int'(wp) + 4);
    endfunction

    // All tasks start and end just after a falling edge
    task automatic do_reset(input logic [AW-1:0] base);
        rst_n = 1'b0;
        base_addr = base;
        wr_inc = 1'b0;
        rd_inc = 1'b0;
        tap_delay = 6'b101_011;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_wp = base;
        m_fill = 0;
        e0 = base;
        e1 = base;
        check("R1 wr_addr", wr_addr, base);
        check("R1 tap0", tap_addr[AW-1:0], base);
        check("R1 tap1", tap_addr[2*AW-1:AW], base);
    endtask

    task automatic write_one();
        wr_inc = 1'b1;
        @(negedge clk);
        wr_inc = 1'b0;
        m_wp = next_wp(m_wp);
        m_fill++;
    endtask

    task automatic sample_step(input int d0, input int d1);
        write_one();
        tap_delay = {DW'(d1), DW'(d0)};
        rd_inc = 1'b1;
        @(negedge clk);
        rd_inc = 1'b0;
        @(negedge clk);
        @(negedge clk);
        e0 = exp_tap(m_wp, m_fill, d0);
        e1 = exp_tap(m_wp, m_fill, d1);
        check("R2/R3 wr_addr", wr_addr, m_wp);
        check("R4 R5 R6 R10 R11 tap0", tap_addr[AW-1:0], e0);
        check("R4 R5 R6 R10 R11 tap1", tap_addr[2*AW-1:AW], e1);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset(16'h0100);
        for (int s = 0; s < 48; s++) begin
            sample_step(s % 8, (s * 3 + 1) % 8);
        end

        // R8: tap 0 moves one edge before tap 1
        write_one();
        tap_delay = {3'd2, 3'd5};
        rd_inc = 1'b1;
        @(negedge clk);
        rd_inc = 1'b0;
        @(negedge clk);
        check("R8 tap0 updated first", tap_addr[AW-1:0], exp_tap(m_wp, m_fill, 5));
        check("R8 tap1 still old", tap_addr[2*AW-1:AW], e1);
        @(negedge clk);
        e0 = exp_tap(m_wp, m_fill, 5);
        e1 = exp_tap(m_wp, m_fill, 2);
        check("R8 tap1 updated", tap_addr[2*AW-1:AW], e1);

        // R9: strobe during the update is ignored
        write_one();
        tap_delay = {3'd6, 3'd1};
        rd_inc = 1'b1;
        @(negedge clk);
        tap_delay = {3'd0, 3'd7};
        @(negedge clk);
        rd_inc = 1'b0;
        @(negedge clk);
        e0 = exp_tap(m_wp, m_fill, 1);
        e1 = exp_tap(m_wp, m_fill, 6);
        check("R9 tap0 keeps first delay", tap_addr[AW-1:0], e0);
        check("R9 tap1 keeps first delay", tap_addr[2*AW-1:AW], e1);
        repeat (3) @(negedge clk);
        check("R9 no second update tap0", tap_addr[AW-1:0], e0);
        check("R9 no second update tap1", tap_addr[2*AW-1:AW], e1);

        // R7 and R2 hold: new delays and no strobes
        tap_delay = {3'd3, 3'd4};
        repeat (6) @(negedge clk);
        check("R7 tap0 unchanged", tap_addr[AW-1:0], e0);
        check("R7 tap1 unchanged", tap_addr[2*AW-1:AW], e1);
        check("R2 wr_addr held", wr_addr, m_wp);

        // Adjacent second buffer starting right after the first
        do_reset(16'h0140);
        for (int s = 0; s < 40; s++) begin
            sample_step((s * 5 + 7) % 8, 7 - (s % 8));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule